// File: doc/BRIEF.md
# Banked Interrupt Controller with Trigger Configuration

This block gathers interrupt request lines into banks of 32 and presents one combined request per bank to a processor. Each line can be set up to act on a level, active high or active low, or on an edge, rising or falling. Edge events are held in a pending bit until software clears them. Software can also raise a pending bit on purpose, for example to test a handler.

A simple single-cycle register bus gives access to the per-bank registers. A write is taken on the rising clock edge while select and write are high. Read data is combinational from the address. Alongside each combined request, the block reports the lowest-numbered source in that bank that is both pending and enabled, so a handler knows at once which source to service.

The request lines are asynchronous to the clock and pass through a two-stage synchroniser before any trigger logic sees them.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Bank b occupies byte addresses b*0x18 to b*0x18+0x17. The word offsets within a bank are: status 0x0, enable 0x4, set 0x8, clear 0xC, polarity 0x10, edge-select 0x14. Global source n is `src_i[n]`, which is bit n&31 of bank n>>5. A read at any unmapped or misaligned address returns 0.
- R2: After reset, the enable, polarity and edge-select registers read 0, all software or edge pending bits are cleared, and every `irq_o` and `pend_vld_o` bit is 0.
- R3: `irq_o[b]` is the OR of (status & enable) of bank b. A source whose enable bit is 0 never asserts `irq_o`, but its status bit can still be read.
- R4: Writing 1 to a bit of the clear register clears that source's pending bit. Bits written as 0 are left unchanged.
- R5: With edge-select 0 (level), the status bit is 1 while the synchronised input is at its active level plus any pending bit from software. The active level is high when polarity is 1 and low when it is 0. An input change appears in status after two clock edges.
- R6: With edge-select 1, a rising edge (polarity 1) or a falling edge (polarity 0) on the input sets the pending bit. The pending bit then holds until it is cleared, and the status bit equals it.
- R7: Writing 1 to a bit of the set register sets that source's pending bit. Reads of the set and clear registers return 0.
- R8: If an active edge is detected in the same cycle as a clear write to the same bit, the pending bit ends up set.
- R9: `pend_vld_o[b]` is 1 when (status & enable) of bank b is non-zero. `pend_idx_o[5*b+4:5*b]` then holds the index of its lowest set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32*NUM_BANKS | Asynchronous interrupt source lines |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | NUM_BANKS | Combined request per bank |
| pend_vld_o | output | NUM_BANKS | Some enabled source pending, per bank |
| pend_idx_o | output | 5*NUM_BANKS | Lowest pending enabled source index, per bank |

## Verification
The hardest case to reach is an active edge that meets a clear write to the same bit in the same clock cycle. The edge only becomes visible inside the block two synchroniser stages after the pin changes, so that moment cannot be seen at the ports. The stimulus handles this by counting edges: it changes the pin and lets exactly two rising edges pass. It then presents the clear write so that the write is taken on the third edge, which is the cycle the pending bit would be set. Random phases mix trigger mode, polarity, mask, set and clear writes with line changes, and compare every bank against a reference model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int SRC_PER_BANK = 32;
    localparam int IDX_W        = $clog2(SRC_PER_BANK);
    localparam int BANK_BYTES   = 24;
    localparam int OFF_W        = 5;

    localparam logic [OFF_W-1:0] OFF_STATUS = 5'h00;
    localparam logic [OFF_W-1:0] OFF_ENABLE = 5'h04;
    localparam logic [OFF_W-1:0] OFF_SET    = 5'h08;
    localparam logic [OFF_W-1:0] OFF_CLEAR  = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_POL    = 5'h10;
    localparam logic [OFF_W-1:0] OFF_EDGE   = 5'h14;

    typedef logic [SRC_PER_BANK-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t en;
        src_vec_t pol;
        src_vec_t edg;
        src_vec_t pend;
        src_vec_t prev;
    } bank_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        vld_o = |req_i;
    end

    p_idx_lowest_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0)));
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  src_vec_t         src_i,
    input  logic             hit_i,
    input  logic             wr_i,
    input  logic [OFF_W-1:0] off_i,
    input  src_vec_t         wdata_i,
    output src_vec_t         rdata_o,
    output logic             irq_o,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o
);
    bank_state_t st_d, st_q;
    src_vec_t    sync_s, act_lvl, act_ev, edge_hit, set_w, clr_w, status, masked;
    logic        wr_en;

    irq_sync #(.W(SRC_PER_BANK)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(sync_s)
    );

    always_comb begin
        wr_en    = hit_i && wr_i;
        act_lvl  = ~(sync_s ^ st_q.pol);
        act_ev   = (sync_s ^ st_q.prev) & act_lvl;
        edge_hit = act_ev & st_q.edg;
        set_w    = (wr_en && off_i == OFF_SET)   ? wdata_i : '0;
        clr_w    = (wr_en && off_i == OFF_CLEAR) ? wdata_i : '0;
        status   = (st_q.edg & st_q.pend) | (~st_q.edg & (act_lvl | st_q.pend));
        masked   = status & st_q.en;

        st_d      = st_q;
        st_d.prev = sync_s;
        st_d.pend = (st_q.pend & ~clr_w) | set_w | edge_hit;
        if (wr_en && off_i == OFF_ENABLE) st_d.en  = wdata_i;
        if (wr_en && off_i == OFF_POL)    st_d.pol = wdata_i;
        if (wr_en && off_i == OFF_EDGE)   st_d.edg = wdata_i;

        rdata_o = '0;
        if (hit_i) begin
            case (off_i)
                OFF_STATUS: rdata_o = status;
                OFF_ENABLE: rdata_o = st_q.en;
                OFF_POL:    rdata_o = st_q.pol;
                OFF_EDGE:   rdata_o = st_q.edg;
                default:    rdata_o = '0;
            endcase
        end
        irq_o = |masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    irq_prio_enc #(.N(SRC_PER_BANK), .IDX_W(IDX_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .req_i(masked), .vld_o(vld_o), .idx_o(idx_o)
    );

    p_clear_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w != '0) |=> ((st_q.pend & $past(clr_w & ~edge_hit)) == '0));

    p_set_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (set_w != '0) |=> ((st_q.pend & $past(set_w)) == $past(set_w)));

    p_edge_wins_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_hit & clr_w) != '0) |=> ((st_q.pend & $past(edge_hit & clr_w)) == $past(edge_hit & clr_w)));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*32-1:0]     src_i,
    input  logic                        bus_sel_i,
    input  logic                        bus_wr_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [31:0]                 bus_wdata_i,
    output logic [31:0]                 bus_rdata_o,
    output logic [NUM_BANKS-1:0]        irq_o,
    output logic [NUM_BANKS-1:0]        pend_vld_o,
    output logic [NUM_BANKS*IDX_W-1:0]  pend_idx_o
);
    localparam int SPAN = NUM_BANKS * BANK_BYTES;

    src_vec_t bank_rdata [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BASE = b * BANK_BYTES;
        logic             hit;
        logic [ADDR_W:0]  rel;

        always_comb begin
            rel = {1'b0, bus_addr_i} - (ADDR_W + 1)'(BASE);
            hit = bus_sel_i && (int'(bus_addr_i) >= BASE) && (int'(bus_addr_i) < BASE + BANK_BYTES);
        end

        irq_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .hit_i  (hit),
            .wr_i   (bus_wr_i),
            .off_i  (rel[OFF_W-1:0]),
            .wdata_i(bus_wdata_i),
            .rdata_o(bank_rdata[b]),
            .irq_o  (irq_o[b]),
            .vld_o  (pend_vld_o[b]),
            .idx_o  (pend_idx_o[b*IDX_W +: IDX_W])
        );

        p_irq_vld_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[b] == pend_vld_o[b]);
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) bus_rdata_o |= bank_rdata[b];
    end

    initial begin
        p_map_fits_r1 : assert (SPAN <= (1 << ADDR_W));
    end
endmodule

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;
    localparam int NB = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB*32-1:0]  src = '0;
    logic              sel = 1'b0, wr = 1'b0;
    logic [7:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NB-1:0]     irq, vld;
    logic [NB*5-1:0]   idx;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_en [NB], m_pol [NB], m_edg [NB], m_pend [NB];

    always #10 clk = ~clk;

    banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .pend_vld_o(vld), .pend_idx_o(idx)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(int b);
        logic [31:0] s, lvl;
        s   = src[b*32 +: 32];
        lvl = ~(s ^ m_pol[b]);
        return (m_edg[b] & m_pend[b]) | (~m_edg[b] & (lvl | m_pend[b]));
    endfunction

    function automatic int lowest(logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic bus_write(int b, int off, logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 1; addr = 8'(b*24 + off); wdata = d;
        @(negedge clk);
        sel = 0; wr = 0;
        case (off)
            4:  m_en[b]  = d;
            8:  m_pend[b] |= d;
            12: m_pend[b] &= ~d;
            16: m_pol[b] = d;
            20: m_edg[b] = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 0;
    endtask

    task automatic drive_src(logic [NB*32-1:0] nv);
        logic [NB*32-1:0] ov;
        ov = src;
        @(negedge clk);
        src = nv;
        for (int b = 0; b < NB; b++) begin
            logic [31:0] o, n;
            o = ov[b*32 +: 32]; n = nv[b*32 +: 32];
            m_pend[b] |= m_edg[b] & ((m_pol[b] & ~o & n) | (~m_pol[b] & o & ~n));
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [31:0] d, ms;
        for (int b = 0; b < NB; b++) begin
            bus_read(8'(b*24), d);
            check({tag, " R5/R6 status"}, d, exp_status(b));
            ms = exp_status(b) & m_en[b];
            check({tag, " R3 irq"}, 32'(irq[b]), 32'(ms != 0));
            check({tag, " R9 vld"}, 32'(vld[b]), 32'(ms != 0));
            if (ms != 0) check({tag, " R9 idx"}, 32'(idx[b*5 +: 5]), 32'(lowest(ms)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int b = 0; b < NB; b++) begin
            m_en[b] = 0; m_pol[b] = 0; m_edg[b] = 0; m_pend[b] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R2 reset state
        check("R2 irq", 32'(irq), 0);
        check("R2 vld", 32'(vld), 0);
        for (int b = 0; b < NB; b++) begin
            bus_read(8'(b*24 + 4), d);  check("R2 enable", d, 0);
            bus_read(8'(b*24 + 16), d); check("R2 polarity", d, 0);
            bus_read(8'(b*24 + 20), d); check("R2 edge", d, 0);
        end
        // R5 active-low level default: status all ones with inputs low
        check_all("reset");

        // R1 unmapped and misaligned reads
        bus_read(8'(NB*24), d);   check("R1 unmapped", d, 0);
        bus_read(8'hFF, d);       check("R1 unmapped high", d, 0);
        bus_read(8'(24 + 1), d);  check("R1 misaligned", d, 0);

        // R3 disabled source still readable, no irq
        bus_write(2, 16, 32'hFFFF_FFFF);
        bus_write(2, 8, 32'h0000_0100);
        check_all("R3 masked");
        check("R3 masked irq", 32'(irq[2]), 0);
        bus_write(2, 4, 32'h0000_0100);
        check_all("R3 enabled");
        check("R3 enabled irq", 32'(irq[2]), 1);

        // R7 set/clear read as zero
        bus_read(8'(2*24 + 8), d);  check("R7 set reads 0", d, 0);
        bus_read(8'(2*24 + 12), d); check("R7 clear reads 0", d, 0);
        // R4 clear only written ones
        bus_write(2, 8, 32'h0000_0600);
        bus_write(2, 12, 32'h0000_0500);
        check_all("R4 clear");

        // R6 edge rising, R9 index, bank 1 bit 3 and bit 7
        bus_write(1, 16, 32'hFFFF_FFFF);
        bus_write(1, 20, 32'hFFFF_FFFF);
        bus_write(1, 4, 32'h0000_0088);
        drive_src(src | (128'(1) << 39) | (128'(1) << 35));
        check_all("R6 rise");
        check("R9 idx lowest", 32'(idx[5 +: 5]), 3);
        drive_src(src & ~(128'(1) << 35));
        check_all("R6 held after fall");
        bus_write(1, 12, 32'h0000_0008);
        check_all("R6 cleared");
        check("R9 idx next", 32'(idx[5 +: 5]), 7);
        bus_write(1, 12, 32'h0000_0080);

        // R8 edge in same cycle as clear
        @(negedge clk);
        src[35] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        sel = 1; wr = 1; addr = 8'(24 + 12); wdata = 32'h0000_0008;
        @(negedge clk);
        sel = 0; wr = 0;
        m_pend[1] |= 32'h0000_0008;
        bus_read(8'(24), d);
        check("R8 edge beats clear", d & 32'h8, 32'h8);
        check_all("R8");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op, b, offs[5];
            offs = '{4, 8, 12, 16, 20};
            op = $urandom_range(0, 5);
            b  = $urandom_range(0, NB-1);
            if (op == 5) drive_src({$urandom, $urandom, $urandom, $urandom});
            else bus_write(b, offs[op], $urandom & $urandom);
            check_all("random");
            if (it % 50 == 0) begin
                bus_read(8'(b*24 + 4), d);  check("R1 enable readback", d, m_en[b]);
                bus_read(8'(b*24 + 20), d); check("R1 edge readback", d, m_edg[b]);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule